// File: doc/BRIEF.md
# PCM Time-Slot Shape Signal Generator

This block makes the enable strobes that pick out CODECs on a PCM highway. A frame sync pulse sets time slot 0. From there the block counts 8-bit slots, and each slot is divided into 16 phases, one phase per half bit period. The block runs on a clock at twice the bit rate, so every clock edge is a phase boundary.

For each of its strobe lanes the block holds a 16-step waveform, stored as a low byte and a high byte. The waveform is played out starting from the least significant bit of the low byte. The lanes work in one of two modes:

- **Dedicated mode:** each lane plays its waveform only during the one slot named by that lane's slot-select register.
- **Slot-number mode:** every lane plays its waveform in every slot, and the current slot number is driven out on a 7-bit bus so an external decoder can build the selects.

A small write port loads the registers. Each lane keeps a shadow copy that the write port changes. The lane uses a separate active copy, which takes the shadow value only at a slot boundary. This keeps a waveform from being torn in the middle of a slot.

Top module: `pcm_shape_gen`

## Requirements
- R1: When `fsync` is high at a clock edge, the cycle after that edge is phase 0 of slot 0, whatever the counters held before. In slot-number mode `slot_num` then reads 0.
- R2: With no sync, the phase steps by one on every clock from 0 to 15. The slot number steps by one only on the edge after phase 15.
- R3: After phase 15 of slot SLOTS-1 (31 by default), the count wraps to slot 0, phase 0, with no sync pulse needed.
- R4: The strobe during phase p (0..15) equals bit p of the 16-bit word {high byte, low byte}. Phases 0..7 take low-byte bits 0..7, and phases 8..15 take high-byte bits 0..7.
- R5: When `mode_slotnum` is 0, strobe i follows its waveform only during the slot equal to its 8-bit select value and is 0 in every other slot. `slot_num` is 0 in this mode.
- R6: When `mode_slotnum` is 1, every strobe follows its waveform in every slot, and `slot_num` shows the current slot.
- R7: Register map: `wr_addr[ADDR_W-1:2]` is the lane index, and `wr_addr[1:0]` is the field. Field 0 is the select, field 1 the low byte, field 2 the high byte. A write to field 3 changes nothing.
- R8: A write takes effect at the first slot boundary (the first edge into phase 0) after the edge that captured the write. The rest of the current slot keeps the old waveform.
- R9: Reset clears all registers, puts the counters at slot 0, phase 0, and drives all outputs to 0. The counters free-run from that point until a sync pulse arrives.
- R10: A select value that names no slot (SLOTS or more) keeps that lane's strobe at 0 in dedicated mode. A select of SLOTS-1 strobes in the last slot.
- R11: All outputs are registered and change in the same cycle that the counters reach the phase they describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, twice the PCM bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync; next cycle is slot 0, phase 0 |
| mode_slotnum | input | 1 | 0 = dedicated select, 1 = slot-number mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Lane index and field |
| wr_data | input | 8 | Write data |
| sel_out | output | NUM_SHAPES (2) | Shape strobes, one per lane |
| slot_num | output | SLOT_W (7) | Current slot in slot-number mode, else 0 |

## Verification
The assertions check the counters and the slot-number bus on every cycle: phase stepping, slot holding within a slot, the frame wrap, realignment to slot 0 after a sync, and the `slot_num` value in each mode. The bit order of the waveforms, the gating of each strobe to its chosen slot, and the rule that writes wait for the next slot boundary depend on register contents. Only the bench's scoreboard can show these, by predicting each strobe cycle by cycle across programmed patterns, mid-slot and on-boundary writes, early syncs, and selects that name no slot.

// File: rtl/pcm_shape_pkg.sv
package pcm_shape_pkg;

   // Phases per slot: 8 bits, two phases per bit
   localparam int PHASES = 16;
   localparam int PH_W   = $clog2(PHASES);

   // Field code carried in wr_addr[1:0]
   typedef enum logic [1:0] {
      FLD_SEL  = 2'd0,
      FLD_LO   = 2'd1,
      FLD_HI   = 2'd2,
      FLD_NONE = 2'd3
   } fld_e;

   // One lane's configuration
   typedef struct packed {
      logic [7:0] sel;
      logic [7:0] lo;
      logic [7:0] hi;
   } shape_cfg_t;

endpackage

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer
   import pcm_shape_pkg::*;
#(
   parameter int SLOTS  = 32,
   parameter int SLOT_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync,
   output logic [PH_W-1:0]   nxt_phase,
   output logic [SLOT_W-1:0] nxt_slot
);

   localparam logic [PH_W-1:0]   LAST_PH   = PH_W'(PHASES - 1);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

   logic [PH_W-1:0]   phase_q;
   logic [SLOT_W-1:0] slot_q;

   // Position for the cycle after this edge
   always_comb begin
      if (fsync) begin
         nxt_phase = '0;
         nxt_slot  = '0;
      end else if (phase_q == LAST_PH) begin
         nxt_phase = '0;
         nxt_slot  = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
      end else begin
         nxt_phase = phase_q + 1'b1;
         nxt_slot  = slot_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         slot_q  <= '0;
      end else begin
         phase_q <= nxt_phase;
         slot_q  <= nxt_slot;
      end
   end

endmodule

// File: rtl/pcm_shape_regs.sv
module pcm_shape_regs
   import pcm_shape_pkg::*;
#(
   parameter int NUM_SHAPES = 2,
   parameter int IDX_W      = 1,
   parameter int ADDR_W     = IDX_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              bound,
   output shape_cfg_t        eff [NUM_SHAPES]
);

   fld_e fld;
   assign fld = fld_e'(wr_addr[1:0]);

   for (genvar g = 0; g < NUM_SHAPES; g++) begin : g_lane
      shape_cfg_t shadow_q;
      shape_cfg_t active_q;
      logic       hit;

      assign hit = wr_en && (wr_addr[ADDR_W-1:2] == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shadow_q <= '0;
         end else if (hit) begin
            case (fld)
               FLD_SEL: shadow_q.sel <= wr_data;
               FLD_LO:  shadow_q.lo  <= wr_data;
               FLD_HI:  shadow_q.hi  <= wr_data;
               default: ;
            endcase
         end
      end

      // Slot-boundary handover keeps a slot's waveform intact
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     active_q <= '0;
         else if (bound) active_q <= shadow_q;
      end

      assign eff[g] = bound ? shadow_q : active_q;
   end

endmodule

// File: rtl/pcm_shape_lane.sv
module pcm_shape_lane
   import pcm_shape_pkg::*;
#(
   parameter int SLOT_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_slotnum,
   input  logic [PH_W-1:0]   nxt_phase,
   input  logic [SLOT_W-1:0] nxt_slot,
   input  shape_cfg_t        cfg,
   output logic              strobe
);

   logic [PHASES-1:0] pattern;
   logic              in_slot;
   logic              nxt_strobe;

   assign pattern    = {cfg.hi, cfg.lo};
   assign in_slot    = (8'(nxt_slot) == cfg.sel);
   assign nxt_strobe = pattern[nxt_phase] & (mode_slotnum | in_slot);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe <= 1'b0;
      else        strobe <= nxt_strobe;
   end

endmodule

// File: rtl/pcm_shape_gen.sv
module pcm_shape_gen
   import pcm_shape_pkg::*;
#(
   parameter int SLOTS      = 32,
   parameter int SLOT_W     = 7,
   parameter int NUM_SHAPES = 2,
   localparam int IDX_W     = (NUM_SHAPES > 1) ? $clog2(NUM_SHAPES) : 1,
   localparam int ADDR_W    = IDX_W + 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fsync,
   input  logic                  mode_slotnum,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [7:0]            wr_data,
   output logic [NUM_SHAPES-1:0] sel_out,
   output logic [SLOT_W-1:0]     slot_num
);

   if (SLOTS < 2 || SLOTS > (1 << SLOT_W)) begin : g_bad_slots
      $error("pcm_shape_gen: SLOTS must fit the slot-number width");
   end
   if (SLOT_W < 1 || SLOT_W > 8) begin : g_bad_slot_w
      $error("pcm_shape_gen: SLOT_W must be 1..8");
   end
   if (NUM_SHAPES < 1 || NUM_SHAPES > 16) begin : g_bad_lanes
      $error("pcm_shape_gen: NUM_SHAPES must be 1..16");
   end
   if (PHASES != 16) begin : g_bad_phases
      $error("pcm_shape_gen: two shape bytes need 16 phases");
   end

   logic [PH_W-1:0]   nxt_phase;
   logic [SLOT_W-1:0] nxt_slot;
   logic              bound;
   shape_cfg_t        eff [NUM_SHAPES];

   pcm_slot_timer #(
      .SLOTS  (SLOTS),
      .SLOT_W (SLOT_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .fsync     (fsync),
      .nxt_phase (nxt_phase),
      .nxt_slot  (nxt_slot)
   );

   assign bound = (nxt_phase == '0);

   pcm_shape_regs #(
      .NUM_SHAPES (NUM_SHAPES),
      .IDX_W      (IDX_W),
      .ADDR_W     (ADDR_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .bound   (bound),
      .eff     (eff)
   );

   for (genvar g = 0; g < NUM_SHAPES; g++) begin : g_out
      pcm_shape_lane #(
         .SLOT_W (SLOT_W)
      ) u_lane (
         .clk          (clk),
         .rst_n        (rst_n),
         .mode_slotnum (mode_slotnum),
         .nxt_phase    (nxt_phase),
         .nxt_slot     (nxt_slot),
         .cfg          (eff[g]),
         .strobe       (sel_out[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_num <= '0;
      else        slot_num <= mode_slotnum ? nxt_slot : '0;
   end

endmodule

// File: rtl/pcm_shape_gen_chk.sv
module pcm_shape_gen_chk
   import pcm_shape_pkg::*;
#(
   parameter int SLOTS  = 32,
   parameter int SLOT_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fsync,
   input logic              mode_slotnum,
   input logic [PH_W-1:0]   nxt_phase,
   input logic [SLOT_W-1:0] nxt_slot,
   input logic [SLOT_W-1:0] slot_num
);

   localparam logic [PH_W-1:0]   LAST_PH   = PH_W'(PHASES - 1);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

   a_r1_sync_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (fsync && mode_slotnum) |=> (slot_num == '0));

   a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
      (nxt_phase != LAST_PH) |=> (fsync || nxt_phase == $past(nxt_phase) + 1'b1));

   a_r2_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (nxt_phase != LAST_PH) |=> (fsync || nxt_slot == $past(nxt_slot)));

   a_r3_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (nxt_phase == LAST_PH && nxt_slot == LAST_SLOT) |=> (nxt_slot == '0 && nxt_phase == '0));

   a_r5_num_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(mode_slotnum) |-> (slot_num == '0));

   a_r6_num_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mode_slotnum) |-> (slot_num == $past(nxt_slot)));

endmodule

bind pcm_shape_gen pcm_shape_gen_chk #(
   .SLOTS  (SLOTS),
   .SLOT_W (SLOT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fsync        (fsync),
   .mode_slotnum (mode_slotnum),
   .nxt_phase    (nxt_phase),
   .nxt_slot     (nxt_slot),
   .slot_num     (slot_num)
);

// File: tb/pcm_shape_gen_bench.sv
`timescale 1ns/1ps
module pcm_shape_gen_bench;

   localparam int SLOTS = 32;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       fsync;
   logic       mode_slotnum;
   logic       wr_en;
   logic [2:0] wr_addr;
   logic [7:0] wr_data;
   logic [1:0] sel_out;
   logic [6:0] slot_num;

   always #2.5 clk = ~clk;

   pcm_shape_gen u_pcm_shape_gen (
      .clk          (clk),
      .rst_n        (rst_n),
      .fsync        (fsync),
      .mode_slotnum (mode_slotnum),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .sel_out      (sel_out),
      .slot_num     (slot_num)
   );

   typedef struct {
      int         cyc;
      logic [1:0] sel;
      logic [6:0] num;
      string      req;
   } exp_t;

   exp_t  q[$];
   exp_t  mon_e;
   int    cyc = 0;
   int    total = 0;
   int    bad = 0;
   string cur_req = "R9";
   bit    finished = 0;

   // Reference model state, from the requirements
   int         m_ph = 0;
   int         m_sl = 0;
   logic [7:0] sh_sel[2], sh_lo[2], sh_hi[2];
   logic [7:0] ac_sel[2], ac_lo[2], ac_hi[2];

   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: compare outputs against queued predictions
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].cyc == cyc) begin
         mon_e = q.pop_front();
         total++;
         if (sel_out !== mon_e.sel || slot_num !== mon_e.num) begin
            bad++;
            $display("FAIL %s cyc=%0d sel_out=%b exp=%b slot_num=%0d exp=%0d",
                     mon_e.req, cyc, sel_out, mon_e.sel, slot_num, mon_e.num);
         end
      end
   end

   // Driver: one phase clock with prediction pushed to the scoreboard
   task automatic tick(input logic fs, input logic we, input logic [2:0] a, input logic [7:0] d);
      int         n_ph, n_sl;
      exp_t       e;
      logic [15:0] pat;
      fsync = fs; wr_en = we; wr_addr = a; wr_data = d;
      if (fs) begin
         n_ph = 0; n_sl = 0;
      end else if (m_ph == 15) begin
         n_ph = 0; n_sl = (m_sl == SLOTS - 1) ? 0 : m_sl + 1;
      end else begin
         n_ph = m_ph + 1; n_sl = m_sl;
      end
      if (n_ph == 0) begin
         for (int c = 0; c < 2; c++) begin
            ac_sel[c] = sh_sel[c]; ac_lo[c] = sh_lo[c]; ac_hi[c] = sh_hi[c];
         end
      end
      for (int c = 0; c < 2; c++) begin
         pat = {ac_hi[c], ac_lo[c]};
         if (mode_slotnum) e.sel[c] = pat[n_ph];
         else              e.sel[c] = (n_sl == int'(ac_sel[c])) ? pat[n_ph] : 1'b0;
      end
      e.num = mode_slotnum ? 7'(n_sl) : 7'd0;
      if (we) begin
         case (a[1:0])
            2'd0: sh_sel[a[2]] = d;
            2'd1: sh_lo[a[2]]  = d;
            2'd2: sh_hi[a[2]]  = d;
            default: ;
         endcase
      end
      m_ph = n_ph; m_sl = n_sl;
      e.cyc = cyc + 1;
      e.req = cur_req;
      q.push_back(e);
      @(posedge clk);
      @(negedge clk);
      fsync = 1'b0; wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 3'd0, 8'd0);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      tick(1'b0, 1'b1, a, d);
   endtask

   task automatic run_to(input int slot, input int ph);
      while (!(m_sl == slot && m_ph == ph)) idle(1);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      for (int c = 0; c < 2; c++) begin
         sh_sel[c] = 0; sh_lo[c] = 0; sh_hi[c] = 0;
         ac_sel[c] = 0; ac_lo[c] = 0; ac_hi[c] = 0;
      end
      rst_n = 1'b0; fsync = 1'b0; mode_slotnum = 1'b0;
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      repeat (3) @(negedge clk);
      // R9: outputs quiet in reset
      total++;
      if (sel_out !== 2'b00 || slot_num !== 7'd0) begin
         bad++;
         $display("FAIL R9 reset sel_out=%b exp=00 slot_num=%0d exp=0", sel_out, slot_num);
      end
      rst_n = 1'b1;
      cur_req = "R9 free-run";
      idle(5);

      cur_req = "R7 writes";
      wr(3'd0, 8'd0);  wr(3'd1, 8'hF8); wr(3'd2, 8'h03);
      wr(3'd4, 8'd1);  wr(3'd5, 8'h1F); wr(3'd6, 8'hF0);
      wr(3'd3, 8'hAA); wr(3'd7, 8'h55);

      cur_req = "R1 sync";
      tick(1'b1, 1'b0, 3'd0, 8'd0);
      cur_req = "R4 R5 R11 dedicated";
      idle(40);
      cur_req = "R3 R5 frame wrap";
      idle(2 * SLOTS * 16);

      cur_req = "R1 early sync";
      run_to(7, 9);
      tick(1'b1, 1'b0, 3'd0, 8'd0);
      idle(40);

      mode_slotnum = 1'b1;
      cur_req = "R6 slot-number";
      idle(16 * 40);

      cur_req = "R8 mid-slot write";
      run_to(4, 5);
      wr(3'd1, 8'h0F);
      idle(30);
      cur_req = "R8 boundary write";
      run_to(10, 15);
      wr(3'd2, 8'hC3);
      idle(40);

      mode_slotnum = 1'b0;
      cur_req = "R10 select range";
      wr(3'd0, 8'd40);
      wr(3'd4, 8'd31);
      tick(1'b1, 1'b0, 3'd0, 8'd0);
      idle(SLOTS * 16 + 20);

      cur_req = "R2 steady";
      idle(100);

      repeat (3) @(negedge clk);
      finished = 1;
      summary();
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

endmodule